// File: doc/BRIEF.md
# Serial Port FIFO Pair with Receive Trigger

This block holds the character buffers of a serial port: one FIFO for characters coming off the line and one for characters waiting to be sent. Each buffer is 16 entries deep and 8 bits wide. Every receive entry also keeps a 3-bit line-error tag. The receiver shifter pushes a character and its tag with a one-cycle valid strobe. The consumer pops with a ready strobe. The transmit side uses the same valid/ready handshake on both of its ends.

A single control write does three things. It can empty either FIFO on its own, since each reset bit clears itself after the write. It selects one of four receive trigger thresholds. It latches a DMA-mode enable bit. The block requests service whenever the receive fill level has reached the threshold. It reports both fill levels in one packed status word. It flags when any stored receive character carries a line error, and it pulses an overrun indication when a character is lost because the receive FIFO is full.

Top module: `uart_fifo_trig`

## Requirements
- R1: Receive characters leave in arrival order, each with its own error tag. `rxOutValid` is high exactly when at least one entry is held, and the FIFO holds up to 16 entries.
- R2: The receive request `rxTrigReq` is high exactly when the receive fill level is at least the threshold chosen by `ctrlData[7:6]` on the last control write: code 0 means 1 entry, 1 means 4, 2 means 8 and 3 means 14.
- R3: The receive fill level sits in `levelWord[3:0]` and the transmit fill level in `levelWord[11:8]`. A FIFO holding 16 entries reports 15. All other bits of `levelWord` are zero.
- R4: A receive character that arrives while the FIFO holds 16 entries and no pop happens in the same cycle is discarded. `rxOverrun` is then high for exactly the next cycle.
- R5: On a full receive FIFO, a push in the same cycle as a pop is accepted with no overrun. On an empty FIFO, a pop request is ignored and a push in the same cycle is still stored.
- R6: `rxErrAny` is high exactly while at least one held receive entry has a nonzero tag. The tag bits are bit 0 parity, bit 1 framing and bit 2 break.
- R7: A control write with `ctrlData[0]` set empties the receive FIFO and drops its tags. A control write with `ctrlData[1]` set empties the transmit FIFO. Each takes effect at that clock edge and leaves the other FIFO untouched. A push or pop aimed at a FIFO in its clear cycle is dropped.
- R8: Transmit characters leave in write order. `txInReady` is low exactly when 16 entries are held, and `txOutValid` is high exactly when at least one entry is held.
- R9: `dmaMode` follows `ctrlData[2]` of the last control write.
- R10: After reset both FIFOs are empty, the threshold code is 0, `dmaMode` is 0 and every request and flag output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlData | input | 8 | Control field: [0] rx clear, [1] tx clear, [2] DMA mode, [7:6] threshold code |
| rxInValid | input | 1 | Received character strobe |
| rxInData | input | 8 | Received character |
| rxInErr | input | 3 | Line-error tag of the received character |
| rxOutValid | output | 1 | Receive FIFO holds a character |
| rxOutReady | input | 1 | Pop the receive head |
| rxOutData | output | 8 | Receive head character |
| rxOutErr | output | 3 | Receive head error tag |
| txInValid | input | 1 | Transmit character write strobe |
| txInReady | output | 1 | Transmit FIFO has room |
| txInData | input | 8 | Transmit character |
| txOutValid | output | 1 | Transmit FIFO holds a character |
| txOutReady | input | 1 | Pop the transmit head |
| txOutData | output | 8 | Transmit head character |
| levelWord | output | 16 | Packed fill levels |
| rxTrigReq | output | 1 | Receive threshold reached |
| rxErrAny | output | 1 | A held receive entry carries an error |
| rxOverrun | output | 1 | A character was discarded in the previous cycle |
| dmaMode | output | 1 | Latched DMA-mode enable |

## Verification
The receive side is filled one entry at a time from empty to full under each of the four threshold codes. Every level between 0 and 16 is therefore seen against every threshold, which separates an off-by-one compare and a wrong code mapping from correct behaviour, and also exercises the saturated level report. At full, a lone push, a push paired with a pop, and a pop on empty with a push in the same cycle tell the overrun rule apart from the simultaneous-access rules. The error flag is swept over each tag bit placed at each of several queue positions, and the FIFO is drained step by step, so the cycle in which the flag drops exposes any wrong tag bookkeeping. Clears are issued to one side while the other holds data and while a push is attempted.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Control field bit positions
  localparam int CtlRxClr  = 0;
  localparam int CtlTxClr  = 1;
  localparam int CtlDma    = 2;
  localparam int CtlTrigLo = 6;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxClr;
    logic txPush;
    logic txPop;
    logic txClr;
  } fifoStrobes_t;

  // Threshold code to receive entry count
  function automatic int unsigned trigDepth(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_ring.sv
module uart_fifo_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  localparam logic [AW-1:0] LastIdx = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LastIdx) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);

endmodule

// File: rtl/uart_fifo_dp.sv
module uart_fifo_dp
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  fifoStrobes_t   stb,
  input  logic [DW-1:0]  rxWrData,
  input  logic [EW-1:0]  rxWrErr,
  input  logic [DW-1:0]  txWrData,
  output logic [DW-1:0]  rxRdData,
  output logic [EW-1:0]  rxRdErr,
  output logic [DW-1:0]  txRdData,
  output logic [CW-1:0]  rxCount,
  output logic [CW-1:0]  txCount,
  output logic           rxFull,
  output logic           rxEmpty,
  output logic           txFull,
  output logic           txEmpty,
  output logic           rxErrAny
);

  logic [DW+EW-1:0] rxRdWord;
  logic [CW-1:0]    errCnt;

  uart_fifo_ring #(.WIDTH(DW + EW), .DEPTH(DEPTH)) i_rxRing (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pop(stb.rxPop), .clr(stb.rxClr),
    .wrData({rxWrErr, rxWrData}), .rdData(rxRdWord),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  uart_fifo_ring #(.WIDTH(DW), .DEPTH(DEPTH)) i_txRing (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.txPop), .clr(stb.txClr),
    .wrData(txWrData), .rdData(txRdData),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  assign rxRdData = rxRdWord[DW-1:0];
  assign rxRdErr  = rxRdWord[DW+EW-1:DW];

  // Number of held receive entries with a nonzero tag
  logic errIn, errOut;
  assign errIn  = stb.rxPush && (rxWrErr != '0);
  assign errOut = stb.rxPop  && (rxRdErr != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errCnt <= '0;
    else if (stb.rxClr) errCnt <= '0;
    else                errCnt <= errCnt + CW'(errIn) - CW'(errOut);
  end

  assign rxErrAny = (errCnt != '0);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlData,
  input  logic          rxInValid,
  input  logic          rxOutReady,
  input  logic          txInValid,
  input  logic          txOutReady,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] txCount,
  input  logic          rxFull,
  input  logic          rxEmpty,
  input  logic          txFull,
  input  logic          txEmpty,
  output fifoStrobes_t  stb,
  output logic          rxOutValid,
  output logic          txInReady,
  output logic          txOutValid,
  output logic [SW-1:0] levelWord,
  output logic          rxTrigReq,
  output logic          rxOverrun,
  output logic          dmaMode
);

  localparam logic [CW-1:0] LevelMax = CW'((1 << LW) - 1);

  logic [1:0] trigCode;
  logic       overrunNow;

  always_comb begin
    stb.rxClr  = ctrlWr && ctrlData[CtlRxClr];
    stb.txClr  = ctrlWr && ctrlData[CtlTxClr];
    stb.rxPop  = rxOutReady && !rxEmpty && !stb.rxClr;
    stb.rxPush = rxInValid && (!rxFull || stb.rxPop) && !stb.rxClr;
    stb.txPop  = txOutReady && !txEmpty && !stb.txClr;
    stb.txPush = txInValid && !txFull && !stb.txClr;
    overrunNow = rxInValid && rxFull && !stb.rxPop && !stb.rxClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigCode  <= 2'd0;
      dmaMode   <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      rxOverrun <= overrunNow;
      if (ctrlWr) begin
        trigCode <= ctrlData[CtlTrigLo +: 2];
        dmaMode  <= ctrlData[CtlDma];
      end
    end
  end

  function automatic logic [LW-1:0] satLevel(input logic [CW-1:0] c);
    return (c > LevelMax) ? LW'(LevelMax) : LW'(c);
  endfunction

  always_comb begin
    levelWord       = '0;
    levelWord[LW-1:0]   = satLevel(rxCount);
    levelWord[8 +: LW]  = satLevel(txCount);
  end

  assign rxTrigReq  = (rxCount >= CW'(trigDepth(trigCode)));
  assign rxOutValid = !rxEmpty;
  assign txInReady  = !txFull;
  assign txOutValid = !txEmpty;

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlData,
  input  logic          rxInValid,
  input  logic [DW-1:0] rxInData,
  input  logic [EW-1:0] rxInErr,
  output logic          rxOutValid,
  input  logic          rxOutReady,
  output logic [DW-1:0] rxOutData,
  output logic [EW-1:0] rxOutErr,
  input  logic          txInValid,
  output logic          txInReady,
  input  logic [DW-1:0] txInData,
  output logic          txOutValid,
  input  logic          txOutReady,
  output logic [DW-1:0] txOutData,
  output logic [15:0]   levelWord,
  output logic          rxTrigReq,
  output logic          rxErrAny,
  output logic          rxOverrun,
  output logic          dmaMode
);

  fifoStrobes_t  stb;
  logic [CW-1:0] rxCount, txCount;
  logic          rxFull, rxEmpty, txFull, txEmpty;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .rxInValid(rxInValid), .rxOutReady(rxOutReady),
    .txInValid(txInValid), .txOutReady(txOutReady),
    .rxCount(rxCount), .txCount(txCount),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .txFull(txFull), .txEmpty(txEmpty),
    .stb(stb), .rxOutValid(rxOutValid), .txInReady(txInReady),
    .txOutValid(txOutValid), .levelWord(levelWord), .rxTrigReq(rxTrigReq),
    .rxOverrun(rxOverrun), .dmaMode(dmaMode)
  );

  uart_fifo_dp #(.DEPTH(DEPTH), .DW(DW), .EW(EW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxWrData(rxInData), .rxWrErr(rxInErr), .txWrData(txInData),
    .rxRdData(rxOutData), .rxRdErr(rxOutErr), .txRdData(txOutData),
    .rxCount(rxCount), .txCount(txCount),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .txFull(txFull), .txEmpty(txEmpty),
    .rxErrAny(rxErrAny)
  );

endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWr,
  input logic [7:0]  ctrlData,
  input logic        rxInValid,
  input logic        rxOutValid,
  input logic        rxOutReady,
  input logic [2:0]  rxOutErr,
  input logic        txInReady,
  input logic [15:0] levelWord,
  input logic        rxTrigReq,
  input logic        rxErrAny,
  input logic        rxOverrun
);

  // R3
  level_pack_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelWord[15:12] == 4'd0 && levelWord[7:4] == 4'd0);

  // R4
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $past(rxInValid && !rxOutReady && levelWord[3:0] == 4'd15));

  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlData[0]) |=> (levelWord[3:0] == 4'd0 && !rxErrAny && !rxOutValid));

  // R8
  tx_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txInReady |-> levelWord[11:8] == 4'd15);

  // R2
  trig_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTrigReq |-> rxOutValid);

  // R6
  err_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOutValid && rxOutErr != 3'd0) |-> rxErrAny);

  // R1
  rx_valid_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOutValid == (levelWord[3:0] != 4'd0));

endmodule

bind uart_fifo_trig uart_fifo_trig_chk i_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
  .rxInValid(rxInValid), .rxOutValid(rxOutValid), .rxOutReady(rxOutReady),
  .rxOutErr(rxOutErr), .txInReady(txInReady), .levelWord(levelWord),
  .rxTrigReq(rxTrigReq), .rxErrAny(rxErrAny), .rxOverrun(rxOverrun)
);

// File: tb/test_uart_fifo_trig.sv
`timescale 1ns/1ps
module test_uart_fifo_trig;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0;
  logic [7:0] ctrlData = '0;
  logic rxInValid = 1'b0;
  logic [7:0] rxInData = '0;
  logic [2:0] rxInErr = '0;
  logic rxOutReady = 1'b0;
  logic txInValid = 1'b0;
  logic [7:0] txInData = '0;
  logic txOutReady = 1'b0;
  logic rxOutValid, txInReady, txOutValid, rxTrigReq, rxErrAny, rxOverrun, dmaMode;
  logic [7:0] rxOutData, txOutData;
  logic [2:0] rxOutErr;
  logic [15:0] levelWord;

  always #10 clk = ~clk;

  uart_fifo_trig i_uart_fifo_trig (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .rxInValid(rxInValid), .rxInData(rxInData), .rxInErr(rxInErr),
    .rxOutValid(rxOutValid), .rxOutReady(rxOutReady), .rxOutData(rxOutData),
    .rxOutErr(rxOutErr), .txInValid(txInValid), .txInReady(txInReady),
    .txInData(txInData), .txOutValid(txOutValid), .txOutReady(txOutReady),
    .txOutData(txOutData), .levelWord(levelWord), .rxTrigReq(rxTrigReq),
    .rxErrAny(rxErrAny), .rxOverrun(rxOverrun), .dmaMode(dmaMode)
  );

  int total = 0;
  int fails = 0;
  logic [10:0] rxQ[$];
  logic [7:0]  txQ[$];
  logic [1:0]  mCode = 2'd0;
  logic        mDma = 1'b0;
  logic        mOv = 1'b0;

  function automatic int thr(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
  endfunction

  function automatic logic [3:0] sat(input int n);
    return (n > 15) ? 4'd15 : 4'(n);
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic anyErr;
    anyErr = 1'b0;
    foreach (rxQ[i]) if (rxQ[i][10:8] != 3'd0) anyErr = 1'b1;
    chk(req, "levelWord", levelWord, {4'd0, sat(txQ.size()), 4'd0, sat(rxQ.size())});
    chk(req, "rxTrigReq", 16'(rxTrigReq), 16'(rxQ.size() >= thr(mCode)));
    chk(req, "rxOutValid", 16'(rxOutValid), 16'(rxQ.size() > 0));
    chk(req, "rxErrAny", 16'(rxErrAny), 16'(anyErr));
    chk(req, "rxOverrun", 16'(rxOverrun), 16'(mOv));
    chk(req, "txInReady", 16'(txInReady), 16'(txQ.size() < 16));
    chk(req, "txOutValid", 16'(txOutValid), 16'(txQ.size() > 0));
    chk(req, "dmaMode", 16'(dmaMode), 16'(mDma));
    if (rxQ.size() > 0) chk(req, "rxHead", 16'({rxOutErr, rxOutData}), 16'(rxQ[0]));
    if (txQ.size() > 0) chk(req, "txHead", 16'(txOutData), 16'(txQ[0]));
  endtask

  // Inputs are set by the caller after a negedge; one clock edge is applied.
  task automatic cycle(input string req);
    logic rc, tc, rpop, rpush, tpop, tpush, ov;
    rc    = ctrlWr && ctrlData[0];
    tc    = ctrlWr && ctrlData[1];
    rpop  = rxOutReady && rxQ.size() > 0 && !rc;
    rpush = rxInValid && (rxQ.size() < 16 || rpop) && !rc;
    ov    = rxInValid && rxQ.size() == 16 && !rpop && !rc;
    tpop  = txOutReady && txQ.size() > 0 && !tc;
    tpush = txInValid && txQ.size() < 16 && !tc;
    @(posedge clk);
    if (rc) rxQ.delete();
    else begin
      if (rpop) void'(rxQ.pop_front());
      if (rpush) rxQ.push_back({rxInErr, rxInData});
    end
    if (tc) txQ.delete();
    else begin
      if (tpop) void'(txQ.pop_front());
      if (tpush) txQ.push_back(txInData);
    end
    if (ctrlWr) begin mCode = ctrlData[7:6]; mDma = ctrlData[2]; end
    mOv = ov;
    @(negedge clk);
    ctrlWr = 0; rxInValid = 0; rxOutReady = 0; txInValid = 0; txOutReady = 0;
    rxInErr = '0;
    checkAll(req);
  endtask

  task automatic ctrlWrite(input logic [7:0] v, input string req);
    ctrlWr = 1; ctrlData = v;
    cycle(req);
  endtask

  task automatic rxPush(input logic [7:0] d, input logic [2:0] e, input string req);
    rxInValid = 1; rxInData = d; rxInErr = e;
    cycle(req);
  endtask

  task automatic rxPop(input string req);
    rxOutReady = 1;
    cycle(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R10");

    // R2 R3 R1 R4 R5: fill sweep under each threshold code
    for (int code = 0; code < 4; code++) begin
      ctrlWrite({2'(code), 6'b000001}, "R2");
      for (int i = 0; i < 16; i++) rxPush(8'(code * 16 + i), 3'd0, "R2");
      rxPush(8'hEE, 3'd0, "R4");          // discarded, overrun next cycle
      cycle("R4");                        // overrun must be gone again
      rxInValid = 1; rxInData = 8'(8'hA0 + code); rxOutReady = 1;
      cycle("R5");                        // push+pop at full
      for (int i = 0; i < 16; i++) rxPop("R1");
      rxPop("R5");                        // pop on empty ignored
    end

    // R5: push and pop together on empty
    rxInValid = 1; rxInData = 8'h5A; rxOutReady = 1;
    cycle("R5");
    rxPop("R5");

    // R6: each tag bit at each of five positions, drained step by step
    for (int b = 0; b < 3; b++)
      for (int pos = 0; pos < 5; pos++) begin
        for (int i = 0; i < 5; i++)
          rxPush(8'(40 + i), (i == pos) ? 3'(1 << b) : 3'd0, "R6");
        for (int i = 0; i < 5; i++) rxPop("R6");
      end

    // R8: transmit fill beyond capacity, then drain, with a push+pop in between
    for (int i = 0; i < 17; i++) begin
      txInValid = 1; txInData = 8'(8'h30 + i);
      cycle("R8");
    end
    txOutReady = 1; txInValid = 1; txInData = 8'h77;
    cycle("R8");
    for (int i = 0; i < 16; i++) begin
      txOutReady = 1;
      cycle("R8");
    end

    // R7: independent clears
    for (int i = 0; i < 3; i++) begin
      rxPush(8'(i), 3'd2, "R7");
      txInValid = 1; txInData = 8'(8'h90 + i);
      cycle("R7");
    end
    ctrlWrite(8'b00000001, "R7");       // rx only; tx keeps 3
    rxPush(8'h11, 3'd4, "R7");
    ctrlWr = 1; ctrlData = 8'b00000010; txInValid = 1; txInData = 8'hBB;
    rxInValid = 1; rxInData = 8'h22;
    cycle("R7");                        // tx cleared, tx push dropped, rx push kept
    ctrlWr = 1; ctrlData = 8'b00000001; rxInValid = 1; rxInData = 8'h33; rxInErr = 3'd1;
    cycle("R7");                        // rx clear beats the push

    // R9: DMA bit follows each write
    ctrlWrite(8'b10000100, "R9");
    ctrlWrite(8'b01000000, "R9");
    ctrlWrite(8'b00000100, "R9");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule